// File: doc/BRIEF.md
# Serial Character Receiver with Error Status

This block receives asynchronous serial characters on a single line. A 16x oversampling strobe is supplied from outside, and the block uses it to find each character's start bit. It takes three samples in the middle of every bit and keeps the majority value. The eight data bits, least significant first, are assembled into a data register. An even-parity bit is optional and a single stop bit closes the frame. At the end of each character the block raises sticky error flags for overrun, noise, framing and parity. It also shows whether a character is in progress.

Software or a sequencer reads the block through a small read port with three registers: a primary status register, a secondary status register holding the receiver-active bit, and the data register. An error flag is cleared only by a two-step sequence. First the primary status register is read while the flag is set, then the data register is read. If a new flag is raised between those two reads, the sequence is abandoned so that the fresh error stays visible.

Top module: `uart_rx_status`

## Requirements
- R1: On an oversampling strobe, a low line while idle starts a frame, and that strobe counts as sample tick 0. If the majority of ticks 7, 8 and 9 of the start bit is 1, the frame is abandoned, no character is stored and the receiver-active bit stays 0.
- R2: Each bit lasts 16 strobes, and its value is the majority of the samples at ticks 7, 8 and 9. Data bits arrive least significant first. A completed character is loaded into the data register (address 2) and sets the ready bit, bit 7 of the primary status register (address 0).
- R3: With `parity_en` high, a parity bit follows the data and the frame uses even parity. A mismatch sets the parity flag, bit 0 of primary status. With `parity_en` low there is no parity bit and the flag is never set.
- R4: A stop-bit majority of 0 sets the framing flag, bit 1 of primary status.
- R5: If the three samples of any bit in a frame (start, data, parity or stop) are not unanimous, the noise flag, bit 2 of primary status, is set when that frame completes.
- R6: If a frame completes while the ready bit is 1 and the data register is not read in that cycle, the overrun flag (bit 3) is set. The data register keeps the earlier character, and the new character and its other errors are discarded.
- R7: A data register read clears exactly those flags that were set at the most recent primary status read. A data read with no preceding status read clears no flag. Any data read clears the ready bit.
- R8: If a frame sets any flag after a primary status read and before the following data read, that data read clears no flag.
- R9: The secondary status register (address 1) has bit 0 = receiver active, and bits 7 to 1 read as 0. Receiver active becomes 1 when the start bit is confirmed and falls when the stop bit is sampled.
- R10: Reads are combinational on `rd_data` for the address on `rd_addr`. Address 3 and the unused bits 6 to 4 of primary status read 0. Only reads with `rd_en` high have side effects.
- R11: If a data read falls in the same cycle as a frame completion, the read returns the old character, the new character is loaded, ready stays 1 and no overrun is flagged.
- R12: After reset, all flags, the ready bit, receiver active and the data register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| parity_en | input | 1 | 1 inserts an even-parity bit after the data |
| rd_en | input | 1 | Read strobe; reads of addresses 0 and 2 have side effects |
| rd_addr | input | 2 | 0 primary status, 1 secondary status, 2 data, 3 unused |
| rd_data | output | DATA_W | Read data for `rd_addr` |

## Verification
The case that matters most is a data register read landing in the same clock edge as the stop-bit decision of the next character. In that cycle the consume path and the load path both act on the ready bit, the data register and the clear sequence. The bench provokes it by raising a data read on exactly the oversampling strobe at tick 9 of the stop bit. It then judges the outcome: the read must return the earlier character, the register must afterwards hold the new one, ready must still be set and overrun must be clear. A second collision, a fresh error arriving between the status read and the data read, is checked by confirming that the older flag survives the data read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP
    } frame_state_e;

    localparam logic [1:0] REG_STAT1 = 2'd0;
    localparam logic [1:0] REG_STAT2 = 2'd1;
    localparam logic [1:0] REG_DATA  = 2'd2;

    // Packing order fixes the primary status bit positions 3..0.
    typedef struct packed {
        logic ovr;
        logic noise;
        logic frame;
        logic par;
    } err_flags_t;

endpackage

// File: rtl/urx_sampler.sv
module urx_sampler #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rx_in,
    input  logic start,
    input  logic run,
    output logic rx_s,
    output logic mid_vld,
    output logic mid_bit,
    output logic mid_noisy,
    output logic bit_end
);
    localparam int CW   = $clog2(OS_RATE);
    localparam int S1   = OS_RATE / 2;
    localparam int S0   = S1 - 1;
    localparam int S2   = S1 + 1;
    localparam int LAST = OS_RATE - 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic [1:0]    smp;
    } smp_state_t;

    smp_state_t q, d;

    always_comb begin
        d         = q;
        d.sync    = {q.sync[0], rx_in};
        rx_s      = q.sync[1];
        mid_vld   = 1'b0;
        bit_end   = 1'b0;
        mid_bit   = (q.smp[0] & q.smp[1]) | (q.smp[0] & rx_s) | (q.smp[1] & rx_s);
        mid_noisy = !((q.smp[0] == q.smp[1]) && (q.smp[1] == rx_s));
        if (os_tick) begin
            if (start) begin
                d.cnt = CW'(1);
            end else if (run) begin
                d.cnt = q.cnt + CW'(1);
                if (q.cnt == CW'(S0)) d.smp[0] = rx_s;
                if (q.cnt == CW'(S1)) d.smp[1] = rx_s;
                mid_vld = (q.cnt == CW'(S2));
                bit_end = (q.cnt == CW'(LAST));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.cnt  <= '0;
            q.smp  <= 2'b11;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/urx_framer.sv
module urx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_s,
    input  logic              parity_en,
    input  logic              mid_vld,
    input  logic              mid_bit,
    input  logic              mid_noisy,
    input  logic              bit_end,
    output logic              start,
    output logic              run,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              err_par,
    output logic              err_frame,
    output logic              err_noise
);
    localparam int IW = $clog2(DATA_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    typedef struct packed {
        frame_state_e      state;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] shreg;
        logic              noise;
        logic              par_err;
        logic              active;
    } fr_state_t;

    fr_state_t q, d;

    always_comb begin
        d         = q;
        start     = (q.state == FR_IDLE) && os_tick && !rx_s;
        run       = (q.state != FR_IDLE);
        done      = 1'b0;
        err_frame = 1'b0;
        err_noise = q.noise | ((q.state == FR_STOP) && mid_noisy);
        unique case (q.state)
            FR_IDLE: begin
                if (start) begin
                    d.state   = FR_START;
                    d.noise   = 1'b0;
                    d.par_err = 1'b0;
                end
            end
            FR_START: begin
                if (mid_vld) begin
                    if (mid_bit) begin
                        d.state = FR_IDLE;
                    end else begin
                        d.active = 1'b1;
                        d.noise  = mid_noisy;
                    end
                end else if (bit_end) begin
                    d.state = FR_DATA;
                    d.idx   = '0;
                end
            end
            FR_DATA: begin
                if (mid_vld) begin
                    d.shreg = {mid_bit, q.shreg[DATA_W-1:1]};
                    d.noise = q.noise | mid_noisy;
                end else if (bit_end) begin
                    if (q.idx == LAST_IDX) begin
                        d.state = parity_en ? FR_PAR : FR_STOP;
                    end else begin
                        d.idx = q.idx + IW'(1);
                    end
                end
            end
            FR_PAR: begin
                if (mid_vld) begin
                    d.par_err = mid_bit ^ (^q.shreg);
                    d.noise   = q.noise | mid_noisy;
                end else if (bit_end) begin
                    d.state = FR_STOP;
                end
            end
            FR_STOP: begin
                if (mid_vld) begin
                    done      = 1'b1;
                    err_frame = !mid_bit;
                    d.active  = 1'b0;
                    d.state   = FR_IDLE;
                end
            end
            default: d.state = FR_IDLE;
        endcase
        active  = q.active;
        rx_byte = q.shreg;
        err_par = q.par_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= FR_IDLE;
            q.idx     <= '0;
            q.shreg   <= '0;
            q.noise   <= 1'b0;
            q.par_err <= 1'b0;
            q.active  <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/urx_regs.sv
module urx_regs
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              err_par,
    input  logic              err_frame,
    input  logic              err_noise,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] stat1,
    output logic [DATA_W-1:0] data_out
);
    localparam int RDY = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        err_flags_t        flags;
        logic              arm;
        err_flags_t        mask;
    } rg_state_t;

    rg_state_t  q, d;
    logic       st_rd, dt_rd, room;
    err_flags_t set_v, clr_v;

    always_comb begin
        d     = q;
        st_rd = rd_en && (rd_addr == REG_STAT1);
        dt_rd = rd_en && (rd_addr == REG_DATA);
        room  = !q.full || dt_rd;
        set_v = '0;
        clr_v = '0;

        if (done) begin
            if (room) begin
                d.data      = rx_byte;
                set_v.par   = err_par;
                set_v.frame = err_frame;
                set_v.noise = err_noise;
            end else begin
                set_v.ovr = 1'b1;
            end
        end

        if (dt_rd && q.arm && (set_v == '0)) clr_v = q.mask;
        d.flags = (q.flags & ~clr_v) | set_v;

        if (dt_rd)        d.full = 1'b0;
        if (done && room) d.full = 1'b1;

        if (dt_rd) d.arm = 1'b0;
        if (st_rd) begin
            d.arm  = 1'b1;
            d.mask = q.flags;
        end
        if (set_v != '0) d.arm = 1'b0;

        stat1      = '0;
        stat1[RDY] = q.full;
        stat1[3:0] = q.flags;
        data_out   = q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              parity_en,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              rx_s, start_w, run_w;
    logic              mid_vld, mid_bit, mid_noisy, bit_end;
    logic              active_w, frame_done;
    logic [DATA_W-1:0] byte_w, stat1_w, data_w;
    logic              e_par, e_frame, e_noise;

    urx_sampler #(.OS_RATE(OS_RATE)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_in     (rx_in),
        .start     (start_w),
        .run       (run_w),
        .rx_s      (rx_s),
        .mid_vld   (mid_vld),
        .mid_bit   (mid_bit),
        .mid_noisy (mid_noisy),
        .bit_end   (bit_end)
    );

    urx_framer #(.DATA_W(DATA_W)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_s      (rx_s),
        .parity_en (parity_en),
        .mid_vld   (mid_vld),
        .mid_bit   (mid_bit),
        .mid_noisy (mid_noisy),
        .bit_end   (bit_end),
        .start     (start_w),
        .run       (run_w),
        .active    (active_w),
        .done      (frame_done),
        .rx_byte   (byte_w),
        .err_par   (e_par),
        .err_frame (e_frame),
        .err_noise (e_noise)
    );

    urx_regs #(.DATA_W(DATA_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (frame_done),
        .rx_byte   (byte_w),
        .err_par   (e_par),
        .err_frame (e_frame),
        .err_noise (e_noise),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .stat1     (stat1_w),
        .data_out  (data_w)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_STAT1: rd_data    = stat1_w;
            REG_STAT2: rd_data[0] = active_w;
            REG_DATA:  rd_data    = data_w;
            default:   rd_data    = '0;
        endcase
    end

endmodule

// File: rtl/urx_checker.sv
module urx_checker
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [1:0]        rd_addr,
    input logic              frame_done,
    input logic              active,
    input logic [DATA_W-1:0] stat1,
    input logic [DATA_W-1:0] data_q
);
    logic data_rd;
    assign data_rd = rd_en && (rd_addr == REG_DATA);

    p_active_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !active);

    p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !frame_done) |=> active);

    p_ready_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> stat1[DATA_W-1]);

    p_overrun_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && stat1[DATA_W-1] && !data_rd) |=> (stat1[3] && data_q == $past(data_q)));

    p_flags_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !data_rd) |=> (stat1[3:0] == $past(stat1[3:0])));

endmodule

bind uart_rx_status urx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .frame_done (frame_done),
    .active     (active_w),
    .stat1      (stat1_w),
    .data_q     (data_w)
);

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       parity_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    uart_rx_status u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_in     (rx_in),
        .parity_en (parity_en),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick_out(input logic v, input logic rd_now, output logic [7:0] val);
        @(negedge clk);
        rx_in = v;
        repeat (2) @(negedge clk);
        os_tick = 1'b1;
        if (rd_now) begin
            rd_en   = 1'b1;
            rd_addr = 2'd2;
        end
        #1 val = rd_data;
        @(negedge clk);
        os_tick = 1'b0;
        rd_en   = 1'b0;
    endtask

    task automatic send_bit(input logic v, input logic glitch);
        logic [7:0] dummy;
        for (int t = 0; t < 16; t++) tick_out(v ^ (glitch && t == 8), 1'b0, dummy);
    endtask

    task automatic idle_ticks(input int n);
        logic [7:0] dummy;
        for (int i = 0; i < n; i++) tick_out(1'b1, 1'b0, dummy);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic bad_par, input logic stop_v,
                              input int noise_pos, input logic rd_done,
                              output logic [7:0] rd_val);
        logic [10:0] bits;
        int          nb;
        logic [7:0]  val;
        bits = '0;
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[1+i] = b[i];
        if (parity_en) begin
            bits[9]  = (^b) ^ bad_par;
            bits[10] = stop_v;
            nb = 11;
        end else begin
            bits[9] = stop_v;
            nb = 10;
        end
        rd_val = 8'h00;
        for (int i = 0; i < nb; i++) begin
            for (int t = 0; t < 16; t++) begin
                tick_out(bits[i] ^ (i == noise_pos && t == 8),
                         rd_done && i == nb - 1 && t == 9, val);
                if (rd_done && i == nb - 1 && t == 9) rd_val = val;
            end
        end
        idle_ticks(20);
    endtask

    task automatic clear_all();
        logic [7:0] v;
        rd(2'd0, v);
        rd(2'd2, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R12 status1 after reset", v, 8'h00);
        rd(2'd1, v); chk("R12 R9 status2 after reset", v, 8'h00);
        rd(2'd2, v); chk("R12 data after reset", v, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] v, x;
        send_frame(8'hA5, 1'b0, 1'b1, -1, 1'b0, x);
        rd(2'd0, v); chk("R2 ready after frame", v, 8'h80);
        rd(2'd2, v); chk("R2 data LSB first", v, 8'hA5);
        rd(2'd0, v); chk("R7 ready cleared by data read", v, 8'h00);
    endtask

    task automatic t_active();
        logic [7:0] v, b;
        b = 8'h96;
        send_bit(1'b0, 1'b0);
        rd(2'd1, v); chk("R9 active after confirmed start", v, 8'h01);
        for (int i = 0; i < 8; i++) send_bit(b[i], 1'b0);
        rd(2'd1, v); chk("R9 active during data", v, 8'h01);
        send_bit(1'b1, 1'b0);
        rd(2'd1, v); chk("R9 active cleared after stop", v, 8'h00);
        idle_ticks(20);
        rd(2'd2, v); chk("R2 data via manual bits", v, 8'h96);
    endtask

    task automatic t_false_start();
        logic [7:0] v, d;
        for (int i = 0; i < 5; i++) tick_out(1'b0, 1'b0, d);
        idle_ticks(25);
        rd(2'd1, v); chk("R1 false start leaves active low", v, 8'h00);
        rd(2'd0, v); chk("R1 false start stores nothing", v, 8'h00);
    endtask

    task automatic t_parity();
        logic [7:0] v, x;
        parity_en = 1'b1;
        send_frame(8'h3C, 1'b0, 1'b1, -1, 1'b0, x);
        rd(2'd0, v); chk("R3 good even parity", v, 8'h80);
        rd(2'd2, v); chk("R3 data with parity", v, 8'h3C);
        send_frame(8'h5B, 1'b1, 1'b1, -1, 1'b0, x);
        rd(2'd0, v); chk("R3 parity flag", v, 8'h81);
        rd(2'd2, v); chk("R3 data with bad parity", v, 8'h5B);
        rd(2'd0, v); chk("R7 parity flag cleared by sequence", v, 8'h00);
        parity_en = 1'b0;
    endtask

    task automatic t_framing();
        logic [7:0] v, x;
        send_frame(8'h0F, 1'b0, 1'b0, -1, 1'b0, x);
        rd(2'd0, v); chk("R4 framing flag", v, 8'h82);
        rd(2'd1, v); chk("R1 line low after bad stop is a false start", v, 8'h00);
        rd(2'd2, v); chk("R4 data kept", v, 8'h0F);
        rd(2'd0, v); chk("R7 framing cleared", v, 8'h00);
    endtask

    task automatic t_noise();
        logic [7:0] v, x;
        send_frame(8'h5A, 1'b0, 1'b1, 3, 1'b0, x);
        rd(2'd0, v); chk("R5 noise flag", v, 8'h84);
        rd(2'd2, v); chk("R5 majority keeps data", v, 8'h5A);
        send_frame(8'hC3, 1'b0, 1'b1, 9, 1'b0, x);
        rd(2'd0, v); chk("R5 noise on stop bit", v, 8'h84);
        clear_all();
        rd(2'd0, v); chk("R7 noise cleared", v, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] v, x;
        send_frame(8'h33, 1'b0, 1'b1, -1, 1'b0, x);
        send_frame(8'h44, 1'b0, 1'b0, -1, 1'b0, x);
        rd(2'd0, v); chk("R6 overrun only, new errors dropped", v, 8'h88);
        rd(2'd2, v); chk("R6 earlier character kept", v, 8'h33);
        rd(2'd0, v); chk("R7 overrun cleared", v, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v, got;
        send_frame(8'h11, 1'b0, 1'b1, -1, 1'b0, got);
        send_frame(8'h22, 1'b0, 1'b1, -1, 1'b1, got);
        chk("R11 colliding read returns old character", got, 8'h11);
        rd(2'd0, v); chk("R11 ready kept, no overrun", v, 8'h80);
        rd(2'd2, v); chk("R11 new character loaded", v, 8'h22);
    endtask

    task automatic t_cancel();
        logic [7:0] v, x;
        parity_en = 1'b1;
        send_frame(8'h3C, 1'b1, 1'b1, -1, 1'b0, x);
        rd(2'd2, v); chk("R7 data read without status read", v, 8'h3C);
        rd(2'd0, v); chk("R7 flag survives unarmed data read", v, 8'h01);
        send_frame(8'h7E, 1'b0, 1'b1, 4, 1'b0, x);
        rd(2'd2, v); chk("R8 data after new flag", v, 8'h7E);
        rd(2'd0, v); chk("R8 sequence cancelled by new flag", v, 8'h05);
        rd(2'd2, v);
        rd(2'd0, v); chk("R7 rearmed sequence clears both", v, 8'h00);
        parity_en = 1'b0;
    endtask

    task automatic t_addr();
        logic [7:0] v;
        rd(2'd3, v); chk("R10 unused address reads zero", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_active();
        t_false_start();
        t_parity();
        t_framing();
        t_noise();
        t_overrun();
        t_same_cycle();
        t_cancel();
        t_addr();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule